// File: doc/BRIEF.md
# Frame-Number Stream Checker

This block passively observes an AXI4-Stream video output whose test pattern puts one frame-number byte on every byte lane of every beat in a frame. It never drives the stream; it only watches beats that are accepted with both tValid and tReady high.

When a frame begins, the block latches the frame number from byte lane 0. It then checks two things. First, the new number may repeat or skip ahead relative to the previous frame, but it may not go backwards, except across the modulo-256 wrap. Second, every byte lane of every beat must match the latched number. Errors set two sticky flags, one for ordering and one for lane mismatch, and increment a saturating error count. A second saturating counter records the frames that close with tLast.

A frame begins on an accepted beat that has tUser high. It also begins on the first accepted beat after reset or after a tLast beat. A frame that is cut off partway through is never reported as an error.

Top module: `frame_order_checker`

## Requirements
- R1: Directly after reset, orderErr and byteErr are 0 and both errCount and frameCount are 0.
- R2: A beat is observed only in a cycle where tValid and tReady are both high. In any other cycle the flags and both counters keep their values, whatever tData, tUser and tLast carry.
- R3: The first frame after reset latches its number from tData[7:0] on its first beat and is exempt from the ordering check.
- R4: After the first frame, each new frame number must be greater than or equal to the previously latched number. Repeats and skips are legal. A smaller number sets orderErr.
- R5: A smaller number is still legal as a wrap-around when the previous number is at least 256-WRAP_WIN and the new number is below WRAP_WIN. WRAP_WIN defaults to 16.
- R6: Each byte lane i (tData[8i+7:8i]) of every observed beat must equal the frame's latched number, including the lanes of the first beat. Any differing lane sets byteErr.
- R7: A frame starts on an observed beat with tUser high, even in the middle of a frame. It also starts on the first observed beat after reset or after an observed beat with tLast high.
- R8: frameCount increments by one on each observed beat with tLast high and saturates at its all-ones value.
- R9: errCount increments by one for each observed beat that has an ordering error, a lane mismatch, or both, and saturates at its all-ones value.
- R10: A high clrFlags resets orderErr, byteErr and errCount on the next edge. It takes priority over an error in the same cycle and leaves frameCount alone.
- R11: If the stream stops in the middle of a frame, no flag is set and frameCount does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clrFlags | input | 1 | Synchronous clear of the flags and errCount |
| tValid | input | 1 | Observed stream valid |
| tReady | input | 1 | Observed stream ready |
| tData | input | BYTES*8 | Observed stream data |
| tUser | input | 1 | Start-of-frame marker |
| tLast | input | 1 | End-of-frame marker |
| orderErr | output | 1 | Sticky flag for a frame number that went backwards |
| byteErr | output | 1 | Sticky flag for a lane mismatch |
| errCount | output | CNT_W | Saturating count of erroneous beats |
| frameCount | output | CNT_W | Saturating count of closed frames |

## Verification
The bench builds the block with BYTES=4, CNT_W=4 and the default WRAP_WIN=16. The narrow counters put saturation at 15, so a few dozen single-beat frames or bad beats reach both saturation limits. Four lanes are enough to place a mismatch in the top lane, away from lane 0. With the default wrap window, 250 followed by 3 passes as a wrap, while 250 followed by 100 is flagged.

// File: rtl/frame_chk_pkg.sv
package frame_chk_pkg;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic beat;       // accepted beat this cycle
    logic sof;        // this beat opens a frame
    logic checkOrder; // ordering comparison applies to this beat
    logic eof;        // this beat closes a frame
  } ctlStrobes_t;

  // Decide whether a new frame number is acceptable after the previous one
  function automatic logic orderLegal(input logic [7:0] prevNum,
                                      input logic [7:0] newNum,
                                      input int unsigned wrapWin);
    logic fwd;
    logic wrap;
    fwd  = (newNum >= prevNum);
    wrap = (32'(prevNum) >= (32'd256 - wrapWin)) && (32'(newNum) < wrapWin);
    return fwd || wrap;
  endfunction

endpackage

// File: rtl/frame_chk_ctrl.sv
module frame_chk_ctrl
  import frame_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tValid,
  input  logic        tReady,
  input  logic        tUser,
  input  logic        tLast,
  output ctlStrobes_t strb
);

  logic startPend;  // next accepted beat opens a frame
  logic haveRef;    // a reference number has been latched since reset
  logic beatNow;
  logic sofNow;

  assign beatNow = tValid && tReady;
  assign sofNow  = beatNow && (tUser || startPend);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPend <= 1'b1;
      haveRef   <= 1'b0;
    end else begin
      if (beatNow) startPend <= tLast;
      if (sofNow)  haveRef   <= 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.beat       = beatNow;
    strb.sof        = sofNow;
    strb.checkOrder = sofNow && haveRef;
    strb.eof        = beatNow && tLast;
  end

endmodule

// File: rtl/frame_chk_dp.sv
module frame_chk_dp
  import frame_chk_pkg::*;
#(
  parameter int BYTES    = 8,
  parameter int CNT_W    = 16,
  parameter int WRAP_WIN = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrFlags,
  input  ctlStrobes_t        strb,
  input  logic [BYTES*8-1:0] tData,
  output logic               orderErr,
  output logic               byteErr,
  output logic [CNT_W-1:0]   errCount,
  output logic [CNT_W-1:0]   frameCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [7:0]       refByte;
  logic [7:0]       refNow;
  logic [BYTES-1:0] laneBad;
  logic             mismatch;
  logic             orderBad;
  logic             anyErr;

  // Lane 0 of an opening beat is the reference for that same beat
  assign refNow = strb.sof ? tData[7:0] : refByte;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign laneBad[i] = (tData[i*8 +: 8] != refNow);
  end

  assign mismatch = strb.beat && (|laneBad);
  assign orderBad = strb.checkOrder &&
                    !orderLegal(refByte, tData[7:0], WRAP_WIN);
  assign anyErr   = mismatch || orderBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refByte    <= '0;
      orderErr   <= 1'b0;
      byteErr    <= 1'b0;
      errCount   <= '0;
      frameCount <= '0;
    end else begin
      if (strb.sof) refByte <= tData[7:0];
      if (clrFlags) begin
        orderErr <= 1'b0;
        byteErr  <= 1'b0;
        errCount <= '0;
      end else begin
        if (orderBad) orderErr <= 1'b1;
        if (mismatch) byteErr  <= 1'b1;
        if (anyErr && errCount != CNT_MAX) errCount <= errCount + 1'b1;
      end
      if (strb.eof && frameCount != CNT_MAX) frameCount <= frameCount + 1'b1;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrFlags |=> (!orderErr && !byteErr && errCount == '0)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.beat && !clrFlags) |=> ($stable(errCount) && $stable(frameCount)
                                   && $stable(orderErr) && $stable(byteErr))); // R2

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eof && frameCount != CNT_MAX) |=> frameCount == $past(frameCount) + 1'b1); // R8

  AST_ERR_MONO: assert property (@(posedge clk) disable iff (!rstN)
    !clrFlags |=> errCount >= $past(errCount)); // R9

  AST_ORDER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (orderErr && !clrFlags) |=> orderErr); // R4

  AST_BYTE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (byteErr && !clrFlags) |=> byteErr); // R6

endmodule

// File: rtl/frame_order_checker.sv
module frame_order_checker
  import frame_chk_pkg::*;
#(
  parameter int BYTES    = 8,
  parameter int CNT_W    = 16,
  parameter int WRAP_WIN = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrFlags,
  input  logic               tValid,
  input  logic               tReady,
  input  logic [BYTES*8-1:0] tData,
  input  logic               tUser,
  input  logic               tLast,
  output logic               orderErr,
  output logic               byteErr,
  output logic [CNT_W-1:0]   errCount,
  output logic [CNT_W-1:0]   frameCount
);

  ctlStrobes_t strb;

  frame_chk_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tValid (tValid),
    .tReady (tReady),
    .tUser  (tUser),
    .tLast  (tLast),
    .strb   (strb)
  );

  frame_chk_dp #(
    .BYTES    (BYTES),
    .CNT_W    (CNT_W),
    .WRAP_WIN (WRAP_WIN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .clrFlags   (clrFlags),
    .strb       (strb),
    .tData      (tData),
    .orderErr   (orderErr),
    .byteErr    (byteErr),
    .errCount   (errCount),
    .frameCount (frameCount)
  );

endmodule

// File: tb/sim_frame_order_checker.sv
module sim_frame_order_checker;

  localparam int BYTES = 4;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               clrFlags = 1'b0;
  logic               tValid = 1'b0;
  logic               tReady = 1'b0;
  logic [BYTES*8-1:0] tData = '0;
  logic               tUser = 1'b0;
  logic               tLast = 1'b0;
  logic               orderErr;
  logic               byteErr;
  logic [CNT_W-1:0]   errCount;
  logic [CNT_W-1:0]   frameCount;

  int checks = 0;
  int errors = 0;
  int expFrames = 0;

  always #2 clk = ~clk;  // 250 MHz

  frame_order_checker #(.BYTES(BYTES), .CNT_W(CNT_W), .WRAP_WIN(16)) u0 (
    .clk(clk), .rstN(rstN), .clrFlags(clrFlags), .tValid(tValid),
    .tReady(tReady), .tData(tData), .tUser(tUser), .tLast(tLast),
    .orderErr(orderErr), .byteErr(byteErr), .errCount(errCount),
    .frameCount(frameCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; returns at the following negedge
  task automatic cyc(input logic [7:0] v, input logic [7:0] top, input bit usr,
                     input bit lst, input bit vld, input bit rdy, input bit clr);
    tData    = {top, {(BYTES-1){v}}};
    tUser    = usr;
    tLast    = lst;
    tValid   = vld;
    tReady   = rdy;
    clrFlags = clr;
    if (vld && rdy && lst && expFrames < CMAX) expFrames++;
    @(negedge clk);
    tValid   = 1'b0;
    tReady   = 1'b0;
    tUser    = 1'b0;
    tLast    = 1'b0;
    clrFlags = 1'b0;
  endtask

  task automatic beat(input logic [7:0] v, input bit usr, input bit lst);
    cyc(v, v, usr, lst, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic frame(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) beat(v, i == 0, i == n - 1);
  endtask

  task automatic clearAll();
    cyc(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic expectFlags(input string req, input int o, input int b, input int e);
    chk({req, " orderErr"}, int'(orderErr), o);
    chk({req, " byteErr"}, int'(byteErr), b);
    chk({req, " errCount"}, int'(errCount), e);
  endtask

  task automatic testReset();
    expectFlags("R1", 0, 0, 0);
    chk("R1 frameCount", int'(frameCount), 0);
  endtask

  task automatic testFirstAndRepeat();
    frame(8'd50, 3);                       // R3 first frame, no order check
    expectFlags("R3", 0, 0, 0);
    frame(8'd50, 2);                       // R4 repeat
    frame(8'd53, 2);                       // R4 skip
    expectFlags("R4 repeat/skip", 0, 0, 0);
    chk("R8 frames", int'(frameCount), expFrames);
  endtask

  task automatic testBackwards();
    frame(8'd40, 3);
    expectFlags("R4 backwards", 1, 0, 1);  // R9 one bad beat
    clearAll();
    expectFlags("R10 clear", 0, 0, 0);
    chk("R10 frameCount kept", int'(frameCount), expFrames);
  endtask

  task automatic testMismatch();
    cyc(8'd40, 8'd41, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);  // lane 3 off on first beat
    expectFlags("R6 first beat", 0, 1, 1);
    cyc(8'd40, 8'd77, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    expectFlags("R6 later beat", 0, 1, 2);
    clearAll();
  endtask

  task automatic testHandshake();
    int f0;
    f0 = int'(frameCount);
    cyc(8'd1, 8'd9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);   // valid without ready
    cyc(8'd1, 8'd9, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);   // ready without valid
    expectFlags("R2 no beat", 0, 0, 0);
    chk("R2 frameCount", int'(frameCount), f0);
  endtask

  task automatic testWrap();
    frame(8'd250, 1);
    frame(8'd3, 2);
    expectFlags("R5 wrap legal", 0, 0, 0);
    frame(8'd250, 1);
    frame(8'd100, 1);
    expectFlags("R5 outside window", 1, 0, 1);
    clearAll();
  endtask

  task automatic testMidUser();
    beat(8'd120, 1'b1, 1'b0);
    beat(8'd120, 1'b0, 1'b0);
    beat(8'd110, 1'b1, 1'b0);              // new frame opened by tUser, backwards
    expectFlags("R7 tUser start", 1, 0, 1);
    clearAll();
  endtask

  task automatic testPartial();
    int f0;
    f0 = int'(frameCount);
    beat(8'd130, 1'b1, 1'b0);
    beat(8'd130, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    expectFlags("R11 partial", 0, 0, 0);
    chk("R11 frameCount", int'(frameCount), f0);
    cyc(8'd130, 8'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);  // bad beat with clear
    expectFlags("R10 clear wins", 0, 0, 0);
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 20; i++) frame(8'd200, 1);
    chk("R8 saturate", int'(frameCount), CMAX);
    for (int i = 0; i < 20; i++) cyc(8'd200, 8'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 saturate", int'(errCount), CMAX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstAndRepeat();
    testBackwards();
    testMismatch();
    testHandshake();
    testWrap();
    testMidUser();
    testPartial();
    testSaturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule